// File: doc/BRIEF.md
# Fired-Rule Address Generator and Consequent Fetch

This block sits between a table-driven fuzzifier and the rule-strength and defuzzification stages of a two-input fuzzy controller. Each input sample carries, for both controller inputs, the index of the fired even-numbered set and the index of the fired odd-numbered set, each with its membership degree. Index value 0xF marks "no set fired". Because at most two sets overlap on each input, at most four rules can fire. The block builds each rule address by concatenating an input-1 index with an input-2 index. This yields the small hypercube of fired rules directly, with no search of the rule base.

For every defined combination the block reads the rule's singleton consequent from an internal rule-base store that a host loads through a simple write port. It then emits one beat on a valid/ready output stream. The beat carries the absolute rule address, the consequent, and the two degrees that belong to that rule. The beats of one sample come out in increasing address order, and the final one carries a last flag.

Back-pressure: a beat stays on the output, unchanged, for as long as `out_valid` is high and `out_ready` is low. The block stops walking the fired rules until that beat is taken. The input side accepts a sample when `in_valid` and `in_ready` are both high. `in_ready` is asserted during the cycle in which the block finishes the previous sample.

Top module: `fired_rule_fetch`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is low and `in_ready` is high, and every rule-base entry reads as zero until the host writes it.
- R2: Each output beat's `out_rule_addr` equals 0x1800 plus the 8-bit relative address {input-1 index in bits 7:4, input-2 index in bits 3:0}.
- R3: The beats of one sample come out in strictly increasing relative address order. The lower input-1 index comes first, and within it the lower input-2 index comes first, whichever of the even or odd fields carries each index.
- R4: A combination in which either index is 0xF produces no beat. An odd index equal to the even index of the same input is used only once.
- R5: `out_conseq` equals the 8-bit value most recently written by the host to that relative address through `wr_en`/`wr_addr`/`wr_data`, or zero if that address was never written.
- R6: `out_deg1` is the degree paired with the beat's input-1 index, and `out_deg2` is the degree paired with its input-2 index.
- R7: `out_last` is high on the final beat of a sample and low on every other beat. A sample with no defined combination produces no beat at all.
- R8: While `out_valid` is high and `out_ready` is low, the beat stays valid and all its fields stay unchanged. No beat is lost or repeated.
- R9: With `out_ready` held high and samples offered back to back, one sample is accepted every 4 cycles, whatever number of rules it fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample accepted this cycle when in_valid is high |
| in_x1_even_idx | input | 4 | Input-1 fired even set index (0xF = none) |
| in_x1_odd_idx | input | 4 | Input-1 fired odd set index (0xF = none) |
| in_x2_even_idx | input | 4 | Input-2 fired even set index (0xF = none) |
| in_x2_odd_idx | input | 4 | Input-2 fired odd set index (0xF = none) |
| in_x1_even_deg | input | 8 | Degree of the input-1 even set |
| in_x1_odd_deg | input | 8 | Degree of the input-1 odd set |
| in_x2_even_deg | input | 8 | Degree of the input-2 even set |
| in_x2_odd_deg | input | 8 | Degree of the input-2 odd set |
| out_valid | output | 1 | Rule beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_rule_addr | output | 16 | Absolute rule address |
| out_conseq | output | 8 | Rule singleton consequent |
| out_deg1 | output | 8 | Input-1 degree for this rule |
| out_deg2 | output | 8 | Input-2 degree for this rule |
| out_last | output | 1 | Final beat of the sample |
| wr_en | input | 1 | Rule-base write strobe |
| wr_addr | input | 8 | Rule-base relative write address |
| wr_data | input | 8 | Rule-base write data |

## Verification
The hardest case to reach is a stalled beat whose sample still has later slots pending, some of them skipped. In that case the walk must freeze on the held beat, then resume without dropping or repeating a rule, and it must still put the last flag on the right beat. The stimulus reaches this by driving `out_ready` low in an irregular pattern while offering samples that mix 0xF indices and reversed even/odd ordering. A separate phase holds `out_ready` high and offers samples back to back, including ones with zero fired rules, to measure the accept spacing.

// File: rtl/frr_pkg.sv
package frr_pkg;
  // Number of rule slots per sample: two inputs, two fired sets each.
  localparam int SLOTS = 4;
  localparam int SLOT_W = $clog2(SLOTS);
  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/frr_slot_plan.sv
// Orders the fired sets of each input and forms the four candidate slots.
module frr_slot_plan
  import frr_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int DEG_W = 8,
  localparam int REL_W = 2 * IDX_W
) (
  input  logic [IDX_W-1:0]             a_even_idx,
  input  logic [IDX_W-1:0]             a_odd_idx,
  input  logic [IDX_W-1:0]             b_even_idx,
  input  logic [IDX_W-1:0]             b_odd_idx,
  input  logic [DEG_W-1:0]             a_even_deg,
  input  logic [DEG_W-1:0]             a_odd_deg,
  input  logic [DEG_W-1:0]             b_even_deg,
  input  logic [DEG_W-1:0]             b_odd_deg,
  output logic [SLOTS-1:0][REL_W-1:0]  slot_rel,
  output logic [SLOTS-1:0][DEG_W-1:0]  slot_deg1,
  output logic [SLOTS-1:0][DEG_W-1:0]  slot_deg2,
  output logic [SLOTS-1:0]             slot_hit,
  output logic [SLOTS-1:0]             slot_last
);
  localparam logic [IDX_W-1:0] NONE = '1;

  logic [IDX_W-1:0] a_lo, a_hi, b_lo, b_hi;
  logic [DEG_W-1:0] a_lo_d, a_hi_d, b_lo_d, b_hi_d;
  logic             a_lo_ok, a_hi_ok, b_lo_ok, b_hi_ok;

  // The undefined code is the largest value, so it always sorts to the high side.
  always_comb begin
    if (a_even_idx <= a_odd_idx) begin
      a_lo = a_even_idx; a_lo_d = a_even_deg; a_hi = a_odd_idx;  a_hi_d = a_odd_deg;
    end else begin
      a_lo = a_odd_idx;  a_lo_d = a_odd_deg;  a_hi = a_even_idx; a_hi_d = a_even_deg;
    end
    if (b_even_idx <= b_odd_idx) begin
      b_lo = b_even_idx; b_lo_d = b_even_deg; b_hi = b_odd_idx;  b_hi_d = b_odd_deg;
    end else begin
      b_lo = b_odd_idx;  b_lo_d = b_odd_deg;  b_hi = b_even_idx; b_hi_d = b_even_deg;
    end
    a_lo_ok = (a_lo != NONE);
    a_hi_ok = (a_hi != NONE) && (a_hi != a_lo);
    b_lo_ok = (b_lo != NONE);
    b_hi_ok = (b_hi != NONE) && (b_hi != b_lo);
  end

  // Slot bit 1 picks the input-1 side, bit 0 the input-2 side.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam bit SEL_A = s[1];
    localparam bit SEL_B = s[0];
    always_comb begin
      slot_rel[s]  = {SEL_A ? a_hi : a_lo, SEL_B ? b_hi : b_lo};
      slot_deg1[s] = SEL_A ? a_hi_d : a_lo_d;
      slot_deg2[s] = SEL_B ? b_hi_d : b_lo_d;
      slot_hit[s]  = (SEL_A ? a_hi_ok : a_lo_ok) && (SEL_B ? b_hi_ok : b_lo_ok);
    end
    assign slot_last[s] = slot_hit[s] && ~|(slot_hit >> (s + 1));
  end
endmodule

// File: rtl/frr_rule_mem.sv
// Rule-base store: host write port, combinational read, cleared by reset.
module frr_rule_mem #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (we) begin
      store[waddr] <= wdata;
    end
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/frr_seq.sv
// Walks the slots of the held sample, one per cycle unless the output stalls.
module frr_seq
  import frr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  logic  cur_hit,
  input  logic  out_valid,
  input  logic  out_ready,
  output logic  in_ready,
  output logic  accept,
  output logic  load,
  output slot_t cur_slot
);
  logic busy, adv, finish;

  assign adv      = busy && (!cur_hit || !out_valid || out_ready);
  assign finish   = adv && (cur_slot == slot_t'(SLOTS - 1));
  assign in_ready = !busy || finish;
  assign accept   = in_valid && in_ready;
  assign load     = adv && cur_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_slot <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      cur_slot <= '0;
    end else if (finish) begin
      busy     <= 1'b0;
    end else if (adv) begin
      cur_slot <= cur_slot + slot_t'(1);
    end
  end
endmodule

// File: rtl/fired_rule_fetch.sv
module fired_rule_fetch
  import frr_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int DEG_W = 8,
  parameter int CQ_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RB_ORIGIN = 16'h1800,
  localparam int REL_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_x1_even_idx,
  input  logic [IDX_W-1:0]  in_x1_odd_idx,
  input  logic [IDX_W-1:0]  in_x2_even_idx,
  input  logic [IDX_W-1:0]  in_x2_odd_idx,
  input  logic [DEG_W-1:0]  in_x1_even_deg,
  input  logic [DEG_W-1:0]  in_x1_odd_deg,
  input  logic [DEG_W-1:0]  in_x2_even_deg,
  input  logic [DEG_W-1:0]  in_x2_odd_deg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_rule_addr,
  output logic [CQ_W-1:0]   out_conseq,
  output logic [DEG_W-1:0]  out_deg1,
  output logic [DEG_W-1:0]  out_deg2,
  output logic              out_last,
  input  logic              wr_en,
  input  logic [REL_W-1:0]  wr_addr,
  input  logic [CQ_W-1:0]   wr_data
);
  // Held sample
  logic [IDX_W-1:0] s_ae, s_ao, s_be, s_bo;
  logic [DEG_W-1:0] s_aed, s_aod, s_bed, s_bod;

  logic [SLOTS-1:0][REL_W-1:0] rel;
  logic [SLOTS-1:0][DEG_W-1:0] d1, d2;
  logic [SLOTS-1:0]            hit, last;
  logic                        accept, load;
  slot_t                       slot;
  logic [CQ_W-1:0]             rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ae <= '1; s_ao <= '1; s_be <= '1; s_bo <= '1;
      s_aed <= '0; s_aod <= '0; s_bed <= '0; s_bod <= '0;
    end else if (accept) begin
      s_ae  <= in_x1_even_idx; s_ao  <= in_x1_odd_idx;
      s_be  <= in_x2_even_idx; s_bo  <= in_x2_odd_idx;
      s_aed <= in_x1_even_deg; s_aod <= in_x1_odd_deg;
      s_bed <= in_x2_even_deg; s_bod <= in_x2_odd_deg;
    end
  end

  frr_slot_plan #(.IDX_W(IDX_W), .DEG_W(DEG_W)) u_plan (
    .a_even_idx(s_ae), .a_odd_idx(s_ao), .b_even_idx(s_be), .b_odd_idx(s_bo),
    .a_even_deg(s_aed), .a_odd_deg(s_aod), .b_even_deg(s_bed), .b_odd_deg(s_bod),
    .slot_rel(rel), .slot_deg1(d1), .slot_deg2(d2),
    .slot_hit(hit), .slot_last(last)
  );

  frr_seq u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_hit(hit[slot]),
    .out_valid(out_valid), .out_ready(out_ready), .in_ready(in_ready),
    .accept(accept), .load(load), .cur_slot(slot)
  );

  frr_rule_mem #(.AW(REL_W), .DW(CQ_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rel[slot]), .rdata(rd)
  );

  // Output beat register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_rule_addr <= '0;
      out_conseq    <= '0;
      out_deg1      <= '0;
      out_deg2      <= '0;
      out_last      <= 1'b0;
    end else if (load) begin
      out_valid     <= 1'b1;
      out_rule_addr <= RB_ORIGIN + ADDR_W'(rel[slot]);
      out_conseq    <= rd;
      out_deg1      <= d1[slot];
      out_deg2      <= d2[slot];
      out_last      <= last[slot];
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end
endmodule

// File: rtl/fired_rule_fetch_chk.sv
module fired_rule_fetch_chk #(
  parameter int IDX_W = 4,
  parameter int DEG_W = 8,
  parameter int CQ_W = 8,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RB_ORIGIN = 16'h1800
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last,
  input logic [ADDR_W-1:0] out_rule_addr,
  input logic [CQ_W-1:0]   out_conseq,
  input logic [DEG_W-1:0]  out_deg1,
  input logic [DEG_W-1:0]  out_deg2
);
  localparam int REL_W = 2 * IDX_W;
  logic [ADDR_W-1:0] rel_off;
  assign rel_off = out_rule_addr - RB_ORIGIN;

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rule_addr) && $stable(out_conseq)
      && $stable(out_deg1) && $stable(out_deg2) && $stable(out_last));

  // R2
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> rel_off < ADDR_W'(1 << REL_W));

  // R4
  no_undef_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rel_off[REL_W-1:IDX_W] != '1) && (rel_off[IDX_W-1:0] != '1));

  // R3
  rising_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> !out_valid || (out_rule_addr > $past(out_rule_addr)));
endmodule

bind fired_rule_fetch fired_rule_fetch_chk #(
  .IDX_W(IDX_W), .DEG_W(DEG_W), .CQ_W(CQ_W), .ADDR_W(ADDR_W), .RB_ORIGIN(RB_ORIGIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_last(out_last), .out_rule_addr(out_rule_addr), .out_conseq(out_conseq),
  .out_deg1(out_deg1), .out_deg2(out_deg2)
);

// File: tb/fired_rule_fetch_tb.sv
module fired_rule_fetch_tb;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  cq;
    logic [7:0]  d1;
    logic [7:0]  d2;
    logic        last;
  } beat_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1, out_last;
  logic [3:0] x1e = '0, x1o = '0, x2e = '0, x2o = '0;
  logic [7:0] d1e = '0, d1o = '0, d2e = '0, d2o = '0;
  logic [15:0] out_rule_addr;
  logic [7:0] out_conseq, out_deg1, out_deg2;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;

  int checks = 0, errors = 0, cyc = 0;
  bit bp_mode = 1'b0, done = 1'b0;
  logic [7:0] model [256];
  beat_t exp_q [$];
  int last_acc = -1;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fired_rule_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x1_even_idx(x1e), .in_x1_odd_idx(x1o), .in_x2_even_idx(x2e), .in_x2_odd_idx(x2o),
    .in_x1_even_deg(d1e), .in_x1_odd_deg(d1o), .in_x2_even_deg(d2e), .in_x2_odd_deg(d2o),
    .out_valid(out_valid), .out_ready(out_ready), .out_rule_addr(out_rule_addr),
    .out_conseq(out_conseq), .out_deg1(out_deg1), .out_deg2(out_deg2), .out_last(out_last),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Consumer readiness: irregular stalls in back-pressure mode
  initial forever begin
    @(negedge clk);
    out_ready = bp_mode ? ((cyc % 3) != 0 && (cyc % 7) != 2) : 1'b1;
  end

  // Monitor: pop and compare every accepted beat
  initial forever begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n && out_valid && out_ready) begin
      beat_t got, exp;
      got = '{out_rule_addr, out_conseq, out_deg1, out_deg2, out_last};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 R7 unexpected beat got %h expected none", got);
      end else begin
        exp = exp_q.pop_front();
        if (got !== exp) begin
          errors++;
          $display("FAIL R2 R3 R5 R6 R7 R8 beat got %h expected %h", got, exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model[a] = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic send(input logic [3:0] e1, o1, e2, o2,
                      input logic [7:0] de1, do1, de2, do2, input bit chk_gap);
    logic [3:0] l1, h1, l2, h2, i1, i2;
    logic [7:0] dl1, dh1, dl2, dh2;
    beat_t tmp [4];
    int n = 0;
    int t;
    if (e1 <= o1) begin l1 = e1; dl1 = de1; h1 = o1; dh1 = do1; end
    else          begin l1 = o1; dl1 = do1; h1 = e1; dh1 = de1; end
    if (e2 <= o2) begin l2 = e2; dl2 = de2; h2 = o2; dh2 = do2; end
    else          begin l2 = o2; dl2 = do2; h2 = e2; dh2 = de2; end
    for (int a = 0; a < 2; a++) begin
      for (int b = 0; b < 2; b++) begin
        i1 = (a == 1) ? h1 : l1;
        i2 = (b == 1) ? h2 : l2;
        if (i1 != 4'hF && i2 != 4'hF && !(a == 1 && h1 == l1) && !(b == 1 && h2 == l2)) begin
          tmp[n] = '{16'h1800 + {8'h00, i1, i2}, model[{i1, i2}],
                     (a == 1) ? dh1 : dl1, (b == 1) ? dh2 : dl2, 1'b0};
          n++;
        end
      end
    end
    if (n > 0) tmp[n-1].last = 1'b1;
    for (int k = 0; k < n; k++) exp_q.push_back(tmp[k]);
    @(negedge clk);
    in_valid = 1'b1; x1e = e1; x1o = o1; x2e = e2; x2o = o2;
    d1e = de1; d1o = do1; d2e = de2; d2o = do2;
    forever begin
      #(CLK_P/4);
      if (in_ready) break;
      @(negedge clk);
    end
    t = cyc;
    if (chk_gap && last_acc >= 0) begin
      checks++;
      if (t - last_acc != 4) begin
        errors++;
        $display("FAIL R9 accept spacing got %0d expected 4", t - last_acc);
      end
    end
    last_acc = t;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || out_valid) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (2) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset got valid=%b ready=%b expected 0 1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 after reset got valid=%b ready=%b expected 0 1", out_valid, in_ready);
    end
    // R1 R5: unwritten rule base reads zero
    send(4'h0, 4'h1, 4'h2, 4'h1, 8'h11, 8'h22, 8'h33, 8'h44, 1'b0);
    drain();
    // Load rule base, leaving every fifth address unwritten
    for (int a = 0; a < 256; a++)
      if (a % 5 != 0) wr(8'(a), 8'((a * 7 + 3) & 8'hFF));
    // R2 R5 R6: four rules, addresses 0x01 0x02 0x11 0x12
    send(4'h0, 4'h1, 4'h2, 4'h1, 8'h11, 8'h22, 8'h33, 8'h44, 1'b0);
    // R3: odd index below even index on both inputs
    send(4'h4, 4'h3, 4'h2, 4'h1, 8'h05, 8'h06, 8'h07, 8'h08, 1'b0);
    // R4: one undefined set on input 1
    send(4'h2, 4'hF, 4'h2, 4'h3, 8'hA0, 8'hA1, 8'hA2, 8'hA3, 1'b0);
    // R7: no defined combination at all
    send(4'h2, 4'h3, 4'hF, 4'hF, 8'h01, 8'h02, 8'h03, 8'h04, 1'b0);
    // R4 R7: single rule
    send(4'h0, 4'hF, 4'hF, 4'h1, 8'h55, 8'h66, 8'h77, 8'h88, 1'b0);
    // R4: repeated index used once
    send(4'h6, 4'h6, 4'h5, 4'h6, 8'h12, 8'h34, 8'h56, 8'h78, 1'b0);
    drain();
    // R5: overwrite
    wr(8'h12, 8'hC3);
    send(4'h0, 4'h1, 4'h2, 4'h1, 8'h21, 8'h32, 8'h43, 8'h54, 1'b0);
    drain();
    // R9: back-to-back spacing with mixed rule counts
    last_acc = -1;
    send(4'h2, 4'h3, 4'h4, 4'h5, 8'h10, 8'h20, 8'h30, 8'h40, 1'b1);
    send(4'hF, 4'hF, 4'h4, 4'h5, 8'h10, 8'h20, 8'h30, 8'h40, 1'b1);
    send(4'h8, 4'h7, 4'hF, 4'h9, 8'h19, 8'h29, 8'h39, 8'h49, 1'b1);
    send(4'hC, 4'hB, 4'hA, 4'h9, 8'h1A, 8'h2A, 8'h3A, 8'h4A, 1'b1);
    drain();
    // R8: irregular back-pressure
    bp_mode = 1'b1;
    for (int k = 0; k < 12; k++) begin
      logic [3:0] b0, b1;
      b0 = 4'(k % 14);
      b1 = (k % 4 == 3) ? 4'hF : 4'((k + 1) % 14);
      send(b0, b1, 4'((k * 3) % 14), 4'((k * 3 + 1) % 14),
           8'(k), 8'(k + 64), 8'(k + 128), 8'(k + 192), 1'b0);
    end
    drain();
    bp_mode = 1'b0;
    // R7: nothing pending or extra at the end
    checks++;
    if (exp_q.size() != 0 || out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R7 leftover got %0d pending valid=%b expected 0 0", exp_q.size(), out_valid);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule